// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns a parallel character written by a host into one asynchronous serial frame on a single output line. A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. Between frames the line rests high. A set of mode inputs chooses the character length, whether parity is sent and its sense, the stop length, and how many transmit-clock enables make one bit time. The enable comes from an external baud source as `tick_i`.

A holding register sits in front of the shift register. While one character shifts out, the host can load the next one. When the stop period ends and a character is waiting, the next frame starts at once. Two flags report the buffer state. `ready_o` shows that the holding register can take a byte. `empty_o` shows that the holding register and the shift path are both idle. The mode inputs are captured at the start of each frame.

Top module: `async_tx`

## Requirements
- R1: `char_len_i` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Only that many low bits of the written byte are sent.
- R2: A frame is one start bit at 0, then the data bits least significant first, then the parity bit when enabled, then the stop period at 1. The line is 1 whenever no frame is in progress.
- R3: With `par_en_i` at 1, a parity bit follows the data. With `par_odd_i` at 0 the data bits plus the parity bit hold an even number of ones. With `par_odd_i` at 1 they hold an odd number. With `par_en_i` at 0 no parity bit is sent.
- R4: `stop_sel_i` sets the stop length: 0 gives 1 bit time, 1 gives 1.5 bit times, and 2 or 3 give 2 bit times. The 1.5 setting with the x1 factor gives 2 bit times.
- R5: `clk_div_i` sets the bit time: 0 gives 1 tick, 1 gives 16 ticks, and 2 or 3 give 64 ticks. While a frame is in progress, the line changes only on a cycle where `tick_i` is 1.
- R6: When a byte is waiting in the holding register at the end of a stop period, the next start bit follows that stop period with no idle time in between.
- R7: `ready_o` is 1 exactly when the holding register is empty. `empty_o` is 1 exactly when the holding register is empty and no frame is being sent.
- R8: A write while `ready_o` is 0 is ignored. The waiting byte and the frame being sent are not changed.
- R9: After reset, `txd_o`, `ready_o` and `empty_o` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Transmit clock enable from the baud source |
| char_len_i | input | 2 | Character length select |
| par_en_i | input | 1 | Parity enable |
| par_odd_i | input | 1 | Parity sense: 1 selects odd |
| stop_sel_i | input | 2 | Stop length select |
| clk_div_i | input | 2 | Clock factor select (x1, x16, x64) |
| wr_i | input | 1 | Write strobe for a character |
| wr_data_i | input | DATA_W | Character to send |
| ready_o | output | 1 | Holding register can accept a byte |
| empty_o | output | 1 | Holding register and shifter are both idle |
| txd_o | output | 1 | Serial output |

## Verification
The hardest cases to reach from the ports are a write that lands while the holding register is full, and a waiting byte that must start exactly when the stop period ends. To reach them, the bench writes bytes one after another with no gap in the long x16 and x64 modes, and strobes an extra write while `ready_o` is low. It records the line on every cycle and decodes each frame at the centre of every bit. It then measures the high time between frames, so the 1.5 and 2 stop lengths are checked to the exact tick.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int CHAR_MAX_W = 8;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;

  function automatic int unsigned div_ticks(logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 16;
      default: return 64;
    endcase
  endfunction

  // 1.5 stop bits cannot be formed at x1, so that case rounds up to 2
  function automatic int unsigned stop_ticks(logic [1:0] stop_sel, logic [1:0] div_sel);
    int unsigned d;
    d = div_ticks(div_sel);
    case (stop_sel)
      2'd0:    return d;
      2'd1:    return (d == 1) ? 2 : d + d / 2;
      default: return 2 * d;
    endcase
  endfunction

  function automatic logic [CHAR_MAX_W-1:0] char_mask(logic [1:0] sel);
    return {CHAR_MAX_W{1'b1}} >> (2'd3 - sel);
  endfunction

endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (take_i) begin
      valid_q <= 1'b0;
    end else if (wr_i && !valid_q) begin
      valid_q <= 1'b1;
      data_q  <= wr_data_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R8
  ignored_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && valid_q && !take_i) |=> (valid_q && data_q == $past(data_q)));

  // R7
  take_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> valid_q);

endmodule

// File: rtl/async_tx_bitclk.sv
module async_tx_bitclk #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clear_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);

  logic [LEN_W-1:0] cnt_q;

  assign done_o = tick_i && !clear_i && (cnt_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> (cnt_q < len_i));

endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              done_i,
  input  logic              hold_valid_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [1:0]        stop_sel_i,
  input  logic [1:0]        clk_div_i,
  output logic              take_o,
  output logic [LEN_W-1:0]  phase_len_o,
  output logic              busy_o,
  output logic              txd_o
);

  localparam int IDX_W = $clog2(DATA_W);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] sreg_q, sreg_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic [1:0]        len_q, stop_q, div_q;
  logic              pen_q, par_q, par_d, txd_q, txd_d, load;
  logic [IDX_W-1:0]  last_idx;

  assign last_idx = IDX_W'(3'd4 + {1'b0, len_q});

  always_comb begin
    state_d = state_q;
    sreg_d  = sreg_q;
    bidx_d  = bidx_q;
    par_d   = par_q;
    load    = 1'b0;
    case (state_q)
      TX_IDLE:  load = hold_valid_i;
      TX_START: if (done_i) begin
        state_d = TX_DATA;
        bidx_d  = '0;
      end
      TX_DATA:  if (done_i) begin
        sreg_d = sreg_q >> 1;
        if (bidx_q == last_idx) state_d = pen_q ? TX_PAR : TX_STOP;
        else                    bidx_d  = bidx_q + 1'b1;
      end
      TX_PAR:   if (done_i) state_d = TX_STOP;
      TX_STOP:  if (done_i) begin
        if (hold_valid_i) load    = 1'b1;
        else              state_d = TX_IDLE;
      end
      default:  state_d = TX_IDLE;
    endcase
    if (load) begin
      state_d = TX_START;
      sreg_d  = hold_data_i;
      par_d   = ^(hold_data_i & DATA_W'(char_mask(char_len_i))) ^ par_odd_i;
    end
    case (state_d)
      TX_START: txd_d = 1'b0;
      TX_DATA:  txd_d = sreg_d[0];
      TX_PAR:   txd_d = par_d;
      default:  txd_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sreg_q  <= '0;
      bidx_q  <= '0;
      par_q   <= 1'b0;
      txd_q   <= 1'b1;
      len_q   <= 2'd3;
      stop_q  <= 2'd0;
      div_q   <= 2'd0;
      pen_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sreg_q  <= sreg_d;
      bidx_q  <= bidx_d;
      par_q   <= par_d;
      txd_q   <= txd_d;
      if (load) begin
        len_q  <= char_len_i;
        stop_q <= stop_sel_i;
        div_q  <= clk_div_i;
        pen_q  <= par_en_i;
      end
    end
  end

  assign take_o      = load;
  assign busy_o      = (state_q != TX_IDLE);
  assign txd_o       = txd_q;
  assign phase_len_o = (state_q == TX_STOP) ? LEN_W'(stop_ticks(stop_q, div_q))
                                            : LEN_W'(div_ticks(div_q));

  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);

  // R5
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && busy_o) |=> $stable(txd_o));

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DATA_W  = CHAR_MAX_W,
  parameter int MAX_DIV = 64,
  localparam int LEN_W  = $clog2(2 * MAX_DIV) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic [1:0]        stop_sel_i,
  input  logic [1:0]        clk_div_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              ready_o,
  output logic              empty_o,
  output logic              txd_o
);

  logic              hold_valid, take, busy, done;
  logic [DATA_W-1:0] hold_data;
  logic [LEN_W-1:0]  phase_len;

  async_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .valid_o   (hold_valid),
    .data_o    (hold_data)
  );

  async_tx_bitclk #(.LEN_W(LEN_W)) u_bitclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clear_i (!busy),
    .len_i   (phase_len),
    .done_o  (done)
  );

  async_tx_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .done_i       (done),
    .hold_valid_i (hold_valid),
    .hold_data_i  (hold_data),
    .char_len_i   (char_len_i),
    .par_en_i     (par_en_i),
    .par_odd_i    (par_odd_i),
    .stop_sel_i   (stop_sel_i),
    .clk_div_i    (clk_div_i),
    .take_o       (take),
    .phase_len_o  (phase_len),
    .busy_o       (busy),
    .txd_o        (txd_o)
  );

  assign ready_o = !hold_valid;
  assign empty_o = !hold_valid && !busy;

  // R7
  empty_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> ready_o);

  // R2
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> txd_o);

endmodule

// File: tb/async_tx_tb.sv
module async_tx_tb;

  localparam int REC_MAX = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [1:0] stop_sel = 2'd0;
  logic [1:0] clk_div = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ready, empty, txd;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic rec [REC_MAX];
  int   rec_n = 0;
  bit   rec_on = 0;
  logic [7:0] exp_q [4];
  int   exp_n = 0;

  always #10 clk = ~clk;

  async_tx u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .char_len_i (char_len),
    .par_en_i   (par_en),
    .par_odd_i  (par_odd),
    .stop_sel_i (stop_sel),
    .clk_div_i  (clk_div),
    .wr_i       (wr),
    .wr_data_i  (wr_data),
    .ready_o    (ready),
    .empty_o    (empty),
    .txd_o      (txd)
  );

  always @(negedge clk) begin
    if (rec_on && rec_n < REC_MAX) begin
      rec[rec_n] = txd;
      rec_n = rec_n + 1;
    end
  end

  function automatic int bit_ticks(logic [1:0] d);
    return (d == 2'd0) ? 1 : (d == 2'd1) ? 16 : 64;
  endfunction

  function automatic int stop_len(logic [1:0] s, logic [1:0] d);
    int b;
    b = bit_ticks(d);
    if (s == 2'd0) return b;
    if (s == 2'd1) return (b == 1) ? 2 : (b * 3) / 2;
    return 2 * b;
  endfunction

  function automatic logic rec_at(int i);
    return (i < rec_n) ? rec[i] : 1'b1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    while (!ready) @(negedge clk);
    wr = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rec_start();
    rec_n = 0;
    exp_n = 0;
    rec_on = 1;
  endtask

  task automatic wait_empty();
    @(negedge clk);
    while (!empty) @(negedge clk);
    repeat (6) @(negedge clk);
    rec_on = 0;
  endtask

  task automatic decode();
    int pos, p0, b, nb, pe, ps, cnt, st;
    logic [7:0] got, want;
    logic pbit;
    pos = 0;
    b  = bit_ticks(clk_div);
    nb = 5 + int'(char_len);
    pe = par_en ? 1 : 0;
    st = stop_len(stop_sel, clk_div);
    for (int k = 0; k < exp_n; k++) begin
      while (pos < rec_n && rec[pos]) pos++;
      chk(pos < rec_n, "R2 frame missing", k, exp_n);
      if (pos >= rec_n) return;
      p0 = pos;
      chk(rec_at(p0 + b / 2) == 1'b0, "R2 start bit", int'(rec_at(p0 + b / 2)), 0);
      got = '0;
      for (int i = 0; i < nb; i++) got[i] = rec_at(p0 + b * (1 + i) + b / 2);
      want = exp_q[k] & (8'hFF >> (8 - nb));
      chk(got == want, "R1 R5 data bits", int'(got), int'(want));
      if (pe == 1) begin
        pbit = rec_at(p0 + b * (1 + nb) + b / 2);
        chk(pbit == ((^want) ^ par_odd), "R3 parity bit", int'(pbit), int'((^want) ^ par_odd));
      end
      ps = p0 + b * (1 + nb + pe);
      cnt = 0;
      while (ps + cnt < rec_n && rec[ps + cnt]) cnt++;
      if (k < exp_n - 1) chk(cnt == st, "R4 R6 stop length to next start", cnt, st);
      else               chk(cnt >= st, "R4 final stop length", cnt, st);
      pos = ps + cnt;
    end
    cnt = 0;
    for (int i = pos; i < rec_n; i++) if (!rec[i]) cnt++;
    chk(cnt == 0, "R8 no extra frame", cnt, 0);
  endtask

  task automatic push(logic [7:0] b);
    exp_q[exp_n] = b;
    exp_n = exp_n + 1;
    send(b);
  endtask

  task automatic run_cfg(logic [1:0] l, logic pen, logic podd, logic [1:0] s,
                         logic [1:0] d, int n);
    @(negedge clk);
    char_len = l; par_en = pen; par_odd = podd; stop_sel = s; clk_div = d;
    rec_start();
    for (int i = 0; i < n; i++) push(8'($urandom));
    wait_empty();
    decode();
  endtask

  initial begin
    logic t0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9
    chk(txd == 1'b1, "R9 reset txd", int'(txd), 1);
    chk(ready == 1'b1, "R9 reset ready", int'(ready), 1);
    chk(empty == 1'b1, "R9 reset empty", int'(empty), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed stop and factor corners (R4, R5, R6)
    run_cfg(2'd3, 1'b0, 1'b0, 2'd1, 2'd0, 3);
    run_cfg(2'd3, 1'b1, 1'b0, 2'd1, 2'd1, 3);
    run_cfg(2'd0, 1'b1, 1'b1, 2'd1, 2'd2, 2);
    run_cfg(2'd1, 1'b1, 1'b0, 2'd2, 2'd1, 3);
    run_cfg(2'd2, 1'b0, 1'b0, 2'd3, 2'd3, 2);

    // R7 R8: flags while buffered, write ignored while ready low
    @(negedge clk);
    char_len = 2'd3; par_en = 1'b1; par_odd = 1'b1; stop_sel = 2'd0; clk_div = 2'd1;
    rec_start();
    push(8'hA5);
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R7 ready while shifting with empty hold", int'(ready), 1);
    chk(empty == 1'b0, "R7 not empty while shifting", int'(empty), 0);
    push(8'h3C);
    chk(ready == 1'b0, "R7 ready low with hold full", int'(ready), 0);
    wr = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    wr = 1'b0;
    chk(ready == 1'b0, "R8 ignored write keeps hold full", int'(ready), 0);
    wait_empty();
    chk(empty == 1'b1, "R7 empty after last frame", int'(empty), 1);
    decode();

    // R5: line frozen while tick low
    @(negedge clk);
    clk_div = 2'd0; par_en = 1'b0; stop_sel = 2'd0;
    send(8'h55);
    repeat (3) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    t0 = txd;
    repeat (25) @(negedge clk);
    chk(txd == t0, "R5 line stable without tick", int'(txd), int'(t0));
    chk(empty == 1'b0, "R5 frame held without tick", int'(empty), 0);
    tick = 1'b1;
    wait_empty();

    // random mix
    for (int it = 0; it < 24; it++) begin
      run_cfg(2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
              2'($urandom), 1 + int'($urandom_range(2)));
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule